// File: doc/BRIEF.md
# CRTC Display Memory Address Generator

This block produces the video memory address used at every character clock of a raster display controller. At the start of a frame it loads a programmed start address and a preset scanline number. Each scanline re-reads the current character row from its row base. When the scanline count within the row reaches the programmed maximum, the row base moves forward by the row pitch. When the line counter hits a programmed split line, both the row base and the scanline number restart at zero. This gives a split screen, with the lower part showing memory from address 0.

Within a scanline, a character counter steps once per character clock. It can be slowed to every second or every fourth strobe. A fine-pan value of 0 to 3 bytes is added at the start of every scanline. The linear count is then remapped for byte, word or double-word memory organisation. Finally, scanline bits can replace address bits 13 and 14 to form two or four interleaved banks, as older graphics adapters did. The memory access itself happens outside this block.

Top module: `crtc_addr_gen`

## Requirements
- R1: While `rst` is high, the row base, the character count and the scanline number are all zero. With byte mode selected and both bank substitutions off, `mem_addr` and `scan_line` read 0.
- R2: A `frame_start` strobe has priority over the other strobes. It loads the row base from `start_addr` and `scan_line` from `preset_scan`. The character count becomes `start_addr + byte_skip`, and the slow-down phase restarts.
- R3: With `ctl_half_rate` and `ctl_quarter_rate` both clear, each `char_adv` strobe adds 1 to the character count. Without a strobe the count holds.
- R4: With `ctl_half_rate` set and `ctl_quarter_rate` clear, the count advances on every second `char_adv` strobe after a load, starting with the second strobe.
- R5: With `ctl_quarter_rate` set, the count advances on every fourth strobe after a load, starting with the fourth. This setting overrides `ctl_half_rate`.
- R6: A `line_start` strobe with `line_cnt` not equal to `split_line` and `scan_line` below `max_scan` adds 1 to `scan_line`. It keeps the row base and reloads the count with row base + `byte_skip`.
- R7: A `line_start` strobe with `scan_line` equal to `max_scan` clears `scan_line` and adds the row pitch to the row base. The row pitch is `row_offset` times 2 in byte mode, times 4 in word mode and times 8 in double-word mode. The count then reloads from the new base + `byte_skip`.
- R8: A `line_start` strobe with `line_cnt` equal to `split_line` clears the row base and `scan_line`, whatever the scanline position. The count reloads to `byte_skip`.
- R9: Word mode is selected by `ctl_dword` = 0 and `ctl_byte_mode` = 0. In word mode `mem_addr` is the count shifted left one place. Bit 0 takes count bit 15 when `ctl_wrap_hi` = 1 and count bit 13 when it is 0.
- R10: With `ctl_dword` = 1 (over any `ctl_byte_mode`), `mem_addr` is the count rotated left two places: count bits 15:14 go to address bits 1:0. With `ctl_dword` = 0 and `ctl_byte_mode` = 1, the address equals the count.
- R11: After the mode remap, `ctl_no_sub13` = 0 replaces address bit 13 with `scan_line` bit 0. `ctl_no_sub14` = 0 replaces address bit 14 with `scan_line` bit 1.
- R12: The row base and the character count wrap modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock domain clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Strobe: begin a new frame |
| line_start | input | 1 | Strobe: begin the scanline numbered `line_cnt` |
| char_adv | input | 1 | Strobe: one character clock elapsed |
| line_cnt | input | 10 | Number of the scanline being entered |
| start_addr | input | 16 | Display start address |
| row_offset | input | 8 | Row pitch before mode scaling |
| preset_scan | input | 5 | Scanline number loaded at frame start |
| byte_skip | input | 2 | Bytes skipped at the start of each scanline |
| max_scan | input | 5 | Scanlines per character row minus one |
| split_line | input | 10 | Line number at which addressing restarts from 0 |
| ctl_no_sub13 | input | 1 | 0: scanline bit 0 replaces address bit 13 |
| ctl_no_sub14 | input | 1 | 0: scanline bit 1 replaces address bit 14 |
| ctl_half_rate | input | 1 | Advance on every second character strobe |
| ctl_wrap_hi | input | 1 | Word mode: bit 15 (1) or bit 13 (0) feeds bit 0 |
| ctl_byte_mode | input | 1 | 1: byte mode, 0: word mode (unless double-word) |
| ctl_quarter_rate | input | 1 | Advance on every fourth character strobe |
| ctl_dword | input | 1 | Double-word address mode |
| mem_addr | output | 16 | Remapped display memory address |
| scan_line | output | 5 | Scanline number within the character row |

## Verification
The bench builds the block with its default widths: a 16-bit address, a 5-bit scanline and a 10-bit line count. These defaults let start addresses near 0xFFFF reach the modulo-65536 wrap within a few strobes. A row pitch of 255 in double-word mode wraps the row base in a few rows. The defaults also let bits 13 and 15 be set directly, which separates the two word-mode rotation sources and both bank substitutions. A small `max_scan` and a reachable `split_line` bring row advances and the split point within tens of cycles.

// File: rtl/crtc_addr_pkg.sv
package crtc_addr_pkg;

    localparam int ADDR_W = 16;
    localparam int SCAN_W = 5;
    localparam int LINE_W = 10;
    localparam int OFS_W  = 8;
    localparam int SKIP_W = 2;
    localparam int PHASE_W = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SCAN_W-1:0] scan_t;

    typedef enum logic [1:0] {
        AM_BYTE  = 2'd0,
        AM_WORD  = 2'd1,
        AM_DWORD = 2'd2
    } amode_e;

    typedef struct packed {
        amode_e mode;
        logic   wrap_hi;
        logic   no_sub13;
        logic   no_sub14;
    } map_cfg_t;

    function automatic amode_e decode_mode(logic dword, logic byte_mode);
        if (dword)          return AM_DWORD;
        else if (byte_mode) return AM_BYTE;
        else                return AM_WORD;
    endfunction

    function automatic addr_t row_pitch(logic [OFS_W-1:0] ofs, amode_e m);
        addr_t wide;
        wide = addr_t'(ofs);
        case (m)
            AM_DWORD: return wide << 3;
            AM_WORD:  return wide << 2;
            default:  return wide << 1;
        endcase
    endfunction

    function automatic addr_t remap_mode(addr_t a, amode_e m, logic wrap_hi);
        case (m)
            AM_WORD:  return {a[ADDR_W-2:0], (wrap_hi ? a[15] : a[13])};
            AM_DWORD: return {a[ADDR_W-3:0], a[15:14]};
            default:  return a;
        endcase
    endfunction

    function automatic addr_t bank_insert(addr_t a, scan_t s, logic no13, logic no14);
        addr_t r;
        r = a;
        if (!no13) r[13] = s[0];
        if (!no14) r[14] = s[1];
        return r;
    endfunction

endpackage

// File: rtl/crtc_row_tracker.sv
module crtc_row_tracker
    import crtc_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [LINE_W-1:0] split_line,
    input  addr_t             start_addr,
    input  scan_t             preset_scan,
    input  scan_t             max_scan,
    input  addr_t             pitch,
    output addr_t             next_base,
    output scan_t             scan_q
);
    addr_t base_q;
    scan_t scan_d;

    always_comb begin
        next_base = base_q;
        scan_d    = scan_q;
        if (frame_start) begin
            next_base = start_addr;
            scan_d    = preset_scan;
        end else if (line_start) begin
            if (line_cnt == split_line) begin
                next_base = '0;
                scan_d    = '0;
            end else if (scan_q == max_scan) begin
                next_base = base_q + pitch;
                scan_d    = '0;
            end else begin
                scan_d    = scan_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            scan_q <= '0;
        end else begin
            base_q <= next_base;
            scan_q <= scan_d;
        end
    end
endmodule

// File: rtl/crtc_char_counter.sv
module crtc_char_counter
    import crtc_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  addr_t             load_base,
    input  logic [SKIP_W-1:0] skip,
    input  logic              adv,
    input  logic              half_rate,
    input  logic              quarter_rate,
    output addr_t             count_q
);
    logic [PHASE_W-1:0] phase_q;
    logic               step_now;

    always_comb begin
        if (quarter_rate)   step_now = (phase_q == '1);
        else if (half_rate) step_now = phase_q[0];
        else                step_now = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            phase_q <= '0;
        end else if (load) begin
            count_q <= load_base + addr_t'(skip);
            phase_q <= '0;
        end else if (adv) begin
            phase_q <= phase_q + 1'b1;
            if (step_now) count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/crtc_addr_mapper.sv
module crtc_addr_mapper
    import crtc_addr_pkg::*;
(
    input  addr_t    count,
    input  scan_t    scan,
    input  map_cfg_t cfg,
    output addr_t    addr
);
    addr_t moded;

    always_comb begin
        moded = remap_mode(count, cfg.mode, cfg.wrap_hi);
        addr  = bank_insert(moded, scan, cfg.no_sub13, cfg.no_sub14);
    end
endmodule

// File: rtl/crtc_addr_gen.sv
module crtc_addr_gen
    import crtc_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              char_adv,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [OFS_W-1:0]  row_offset,
    input  logic [SCAN_W-1:0] preset_scan,
    input  logic [SKIP_W-1:0] byte_skip,
    input  logic [SCAN_W-1:0] max_scan,
    input  logic [LINE_W-1:0] split_line,
    input  logic              ctl_no_sub13,
    input  logic              ctl_no_sub14,
    input  logic              ctl_half_rate,
    input  logic              ctl_wrap_hi,
    input  logic              ctl_byte_mode,
    input  logic              ctl_quarter_rate,
    input  logic              ctl_dword,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [SCAN_W-1:0] scan_line
);
    map_cfg_t cfg;
    addr_t    pitch;
    addr_t    next_base;
    addr_t    char_addr;
    logic     reload;

    always_comb begin
        cfg.mode     = decode_mode(ctl_dword, ctl_byte_mode);
        cfg.wrap_hi  = ctl_wrap_hi;
        cfg.no_sub13 = ctl_no_sub13;
        cfg.no_sub14 = ctl_no_sub14;
        pitch        = row_pitch(row_offset, cfg.mode);
        reload       = frame_start | line_start;
    end

    crtc_row_tracker u_rows (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .line_start  (line_start),
        .line_cnt    (line_cnt),
        .split_line  (split_line),
        .start_addr  (start_addr),
        .preset_scan (preset_scan),
        .max_scan    (max_scan),
        .pitch       (pitch),
        .next_base   (next_base),
        .scan_q      (scan_line)
    );

    crtc_char_counter u_chars (
        .clk          (clk),
        .rst          (rst),
        .load         (reload),
        .load_base    (next_base),
        .skip         (byte_skip),
        .adv          (char_adv),
        .half_rate    (ctl_half_rate),
        .quarter_rate (ctl_quarter_rate),
        .count_q      (char_addr)
    );

    crtc_addr_mapper u_map (
        .count (char_addr),
        .scan  (scan_line),
        .cfg   (cfg),
        .addr  (mem_addr)
    );
endmodule

// File: rtl/crtc_addr_gen_checker.sv
module crtc_addr_gen_checker
    import crtc_addr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              line_start,
    input logic              char_adv,
    input logic [LINE_W-1:0] line_cnt,
    input logic [LINE_W-1:0] split_line,
    input logic [SCAN_W-1:0] preset_scan,
    input logic [SCAN_W-1:0] max_scan,
    input logic              ctl_half_rate,
    input logic              ctl_quarter_rate,
    input logic [SCAN_W-1:0] scan_line,
    input logic [ADDR_W-1:0] char_addr
);
    AST_RESET_SCAN: assert property (@(posedge clk)
        rst |=> scan_line == '0);  // R1

    AST_FRAME_PRESET: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> scan_line == $past(preset_scan));  // R2

    AST_CHAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !line_start && !char_adv) |=> $stable(char_addr));  // R3

    AST_CHAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (char_adv && !frame_start && !line_start && !ctl_half_rate && !ctl_quarter_rate)
        |=> char_addr == $past(char_addr) + 16'd1);  // R3

    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (rst)
        (line_start && !frame_start && line_cnt != split_line && scan_line != max_scan)
        |=> scan_line == $past(scan_line) + 5'd1);  // R6

    AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !line_start) |=> $stable(scan_line));  // R6

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
        (line_start && !frame_start && scan_line == max_scan) |=> scan_line == '0);  // R7

    AST_SPLIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (line_start && !frame_start && line_cnt == split_line) |=> scan_line == '0);  // R8
endmodule

bind crtc_addr_gen crtc_addr_gen_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .frame_start      (frame_start),
    .line_start       (line_start),
    .char_adv         (char_adv),
    .line_cnt         (line_cnt),
    .split_line       (split_line),
    .preset_scan      (preset_scan),
    .max_scan         (max_scan),
    .ctl_half_rate    (ctl_half_rate),
    .ctl_quarter_rate (ctl_quarter_rate),
    .scan_line        (scan_line),
    .char_addr        (char_addr)
);

// File: tb/crtc_addr_gen_test.sv
module crtc_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 0, line_start = 0, char_adv = 0;
    logic [9:0]  line_cnt = 0, split_line = 10'h3FF;
    logic [15:0] start_addr = 0;
    logic [7:0]  row_offset = 0;
    logic [4:0]  preset_scan = 0, max_scan = 0;
    logic [1:0]  byte_skip = 0;
    logic        ctl_no_sub13 = 1, ctl_no_sub14 = 1, ctl_half_rate = 0, ctl_wrap_hi = 0;
    logic        ctl_byte_mode = 1, ctl_quarter_rate = 0, ctl_dword = 0;
    logic [15:0] mem_addr;
    logic [4:0]  scan_line;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    string cur_req = "R1";
    int m_base = 0, m_scan = 0, m_char = 0, m_ph = 0;

    always #4 clk = ~clk;

    crtc_addr_gen uut (.*);

    function automatic int kfac();
        if (ctl_dword) return 8;
        if (ctl_byte_mode) return 2;
        return 4;
    endfunction

    function automatic logic [15:0] model_addr(int c, int s);
        logic [15:0] a;
        logic [15:0] cv;
        cv = c[15:0];
        if (ctl_dword) a = 16'((c * 4) % 65536 + c / 16384);
        else if (ctl_byte_mode) a = cv;
        else a = 16'((c * 2) % 65536 + (ctl_wrap_hi ? c / 32768 : (c / 8192) % 2));
        if (!ctl_no_sub13) a[13] = s[0];
        if (!ctl_no_sub14) a[14] = (s / 2) % 2 == 1;
        return a;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_base = 0; m_scan = 0; m_char = 0; m_ph = 0;
        end else if (frame_start) begin
            m_base = start_addr; m_scan = preset_scan;
            m_char = (m_base + byte_skip) % 65536; m_ph = 0;
        end else if (line_start) begin
            if (line_cnt == split_line) begin
                m_base = 0; m_scan = 0;
            end else if (m_scan == max_scan) begin
                m_scan = 0; m_base = (m_base + row_offset * kfac()) % 65536;
            end else m_scan = m_scan + 1;
            m_char = (m_base + byte_skip) % 65536; m_ph = 0;
        end else if (char_adv) begin
            bit go;
            go = ctl_quarter_rate ? (m_ph == 3) : ctl_half_rate ? (m_ph % 2 == 1) : 1'b1;
            m_ph = (m_ph + 1) % 4;
            if (go) m_char = (m_char + 1) % 65536;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            logic [15:0] exp_a;
            exp_a = model_addr(m_char, m_scan);
            n_cmp++;
            if (mem_addr !== exp_a || scan_line !== 5'(m_scan)) begin
                n_bad++;
                $display("FAIL %s: addr %h scan %0d, expected addr %h scan %0d",
                         cur_req, mem_addr, scan_line, exp_a, m_scan);
            end
        end
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: cycles %0d, expected below 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step(input bit fs, input bit ls, input bit ca);
        @(negedge clk); #1;
        frame_start = fs; line_start = ls; char_adv = ca;
    endtask

    task automatic chars(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 1);
        step(0, 0, 0);
    endtask

    task automatic lines(input int n, input int chars_per);
        for (int i = 0; i < n; i++) begin
            line_cnt = line_cnt + 1'b1;
            step(0, 1, 0);
            for (int j = 0; j < chars_per; j++) step(0, 0, 1);
        end
        step(0, 0, 0);
    endtask

    task automatic frame(input logic [15:0] sa, input logic [4:0] ps);
        start_addr = sa; preset_scan = ps; line_cnt = 0;
        step(1, 0, 0);
        step(0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++;
        if (mem_addr !== 16'h0 || scan_line !== 5'd0) begin
            n_bad++;
            $display("FAIL R1: addr %h scan %0d, expected 0000 0", mem_addr, scan_line);
        end
        #1 rst = 0;

        cur_req = "R2";  frame(16'h1234, 5'd3);
        cur_req = "R3";  chars(10);
        cur_req = "R4";  ctl_half_rate = 1; frame(16'h0100, 0); chars(9);
        cur_req = "R5";  ctl_quarter_rate = 1; frame(16'h0200, 0); chars(13);
        ctl_half_rate = 0; chars(6); ctl_quarter_rate = 0;
        cur_req = "R6";  max_scan = 2; row_offset = 8'd5; byte_skip = 2'd2;
        frame(16'h0300, 0); lines(2, 3);
        cur_req = "R7";  lines(7, 2);
        ctl_byte_mode = 0; lines(6, 2);
        ctl_dword = 1; lines(6, 2); ctl_dword = 0; ctl_byte_mode = 1;
        cur_req = "R8";  split_line = 10'd4; frame(16'h4000, 1); lines(6, 2);
        split_line = 10'h3FF;
        cur_req = "R9";  ctl_byte_mode = 0; byte_skip = 0;
        frame(16'hA001, 0); chars(3); ctl_wrap_hi = 1; chars(2);
        frame(16'h6000, 0); chars(2); ctl_wrap_hi = 0; chars(2);
        cur_req = "R10"; ctl_dword = 1; frame(16'hC003, 0); chars(3);
        ctl_byte_mode = 1; chars(2); ctl_dword = 0; chars(2);
        cur_req = "R11"; ctl_no_sub13 = 0; frame(16'h0010, 0); lines(4, 2);
        ctl_no_sub14 = 0; lines(4, 2); ctl_no_sub13 = 1; lines(3, 1);
        ctl_byte_mode = 0; frame(16'hFFF0, 1); lines(3, 1);
        ctl_no_sub14 = 1; ctl_byte_mode = 1;
        cur_req = "R12"; byte_skip = 2'd3; frame(16'hFFFE, 0); chars(6);
        ctl_dword = 1; row_offset = 8'hFF; max_scan = 0; lines(40, 1);
        ctl_dword = 0;
        cur_req = "R1";  rst = 1; step(0, 0, 0); step(0, 0, 0); rst = 0; step(0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule